// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block manages a bank of general-purpose I/O lines behind a small register interface. Software sets a direction per line, writes a data latch that drives the output lines, and turns on pull-ups for groups of four lines. Reading the data register returns the pin level for input lines and the latch for output lines. A force bit in the control register makes every bit of that read return the latch instead.

Toward the pads the block drives output enable, output data and pull-up enable for each line. Peripherals can take over any line through an override enable and an override data bit. While the chip runs in bus-expansion mode, a lock mask protects the direction and latch bits of lines used by the external bus. Pull-ups for the four-line groups that contain those lines are held off. A separate sense line shares its pin with an interrupt input. It has no direction bit and never drives, and its level can be read at its own offset. All pin levels pass through a two-stage synchronizer before they reach the read path.

Register offsets: 0 direction, 1 data, 2 pull-up group enables, 3 control (bit 0 = force latch read-back), 4 sense (bit 0 = sense level, read only). Any other offset reads as zero and ignores writes.

Top module: `gpio_port`

## Requirements
- R1: After reset all direction, latch, pull-up and control bits are 0. Every padOe and pullEn bit is 0, and reads of offsets 0, 2 and 3 return 0.
- R2: Direction bit i set to 1 makes padOe[i] 1. Set to 0, padOe[i] is 0 unless a peripheral override is active on that line.
- R3: With force off, a read of offset 1 returns, for each bit, the latch where the direction is 1 and the synchronized pin where it is 0. A pin change shows up after exactly two rising clock edges.
- R4: A write to offset 1 updates the latch whatever the direction. padOut[i] equals latch bit i on lines without a peripheral override.
- R5: Pull-up register bit g covers lines 4g to 4g+3. pullEn[i] is 1 only while that group bit is 1 and line i is not driving (padOe[i] is 0).
- R6: When periphOe[i] is 1, padOe[i] is 1 and padOut[i] equals periphOut[i], whatever direction bit i holds.
- R7: While busMode is 1, writes to offsets 0 and 1 leave the bits flagged in lockMask unchanged and update the unflagged bits.
- R8: While busMode is 1, a pull-up group that contains any locked line stays writable and readable at offset 2, but its pullEn bits are 0. Clearing busMode restores them.
- R9: With control bit 0 set to 1, a read of offset 1 returns the latch for every bit, whatever the direction.
- R10: A read of offset 4 returns the synchronized sense pin level in bit 0 and zero in every other bit. Writes to offset 4 have no effect.
- R11: rdData is 0 while rdEn is low and when an unused offset is read. Read data is valid in the same cycle as rdEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | NUM_LINES | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | NUM_LINES | Read data, valid with rdEn |
| pinIn | input | NUM_LINES | Asynchronous pad input levels |
| senseIn | input | 1 | Asynchronous level of the shared interrupt/sense pin |
| periphOe | input | NUM_LINES | Per-line peripheral output override enable |
| periphOut | input | NUM_LINES | Per-line peripheral output data |
| busMode | input | 1 | Bus-expansion mode active |
| lockMask | input | NUM_LINES | Lines owned by the external bus |
| padOe | output | NUM_LINES | Pad output enable |
| padOut | output | NUM_LINES | Pad output data |
| pullEn | output | NUM_LINES | Pad pull-up enable |

## Verification
The hardest situation to reach is one where bus-expansion lock, peripheral override and direction all act on the same four-line group. A locked group must still accept pull-up register writes while holding its pull-ups off, and a write to the direction register must then keep the locked bits and update the rest. The stimulus sets up a known latch value first, enters bus mode with a partial lock mask, and uses the force-latch read to show the merged latch contents at the port. The same sequence shows the pull-up outputs of the locked group coming back as soon as bus mode is cleared.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int OFF_DIR   = 0;
  localparam int OFF_DATA  = 1;
  localparam int OFF_PULL  = 2;
  localparam int OFF_CTRL  = 3;
  localparam int OFF_SENSE = 4;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_DATA,
    RD_PULL,
    RD_CTRL,
    RD_SENSE
  } readSel_t;

  typedef struct packed {
    logic     wrDir;
    logic     wrData;
    logic     wrPull;
    logic     wrCtrl;
    readSel_t rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (wrEn) begin
      case (addr)
        ADDR_W'(OFF_DIR):  stb.wrDir  = 1'b1;
        ADDR_W'(OFF_DATA): stb.wrData = 1'b1;
        ADDR_W'(OFF_PULL): stb.wrPull = 1'b1;
        ADDR_W'(OFF_CTRL): stb.wrCtrl = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (addr)
        ADDR_W'(OFF_DIR):   stb.rdSel = RD_DIR;
        ADDR_W'(OFF_DATA):  stb.rdSel = RD_DATA;
        ADDR_W'(OFF_PULL):  stb.rdSel = RD_PULL;
        ADDR_W'(OFF_CTRL):  stb.rdSel = RD_CTRL;
        ADDR_W'(OFF_SENSE): stb.rdSel = RD_SENSE;
        default:            stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int GRP_SIZE  = 4,
  localparam int GROUPS   = NUM_LINES / GRP_SIZE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          stb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] pinSync,
  input  logic                 senseSync,
  input  logic [NUM_LINES-1:0] periphOe,
  input  logic [NUM_LINES-1:0] periphOut,
  input  logic                 busMode,
  input  logic [NUM_LINES-1:0] lockMask,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] pullEn,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_LINES-1:0] dirQ,
  output logic [NUM_LINES-1:0] latchQ
);
  logic [GROUPS-1:0]    pullQ;
  logic                 forceLatch;
  logic [NUM_LINES-1:0] wrMask;
  logic [GROUPS-1:0]    grpLocked;
  logic [NUM_LINES-1:0] dataView;

  // bus-owned lines refuse direction and latch writes
  assign wrMask = busMode ? ~lockMask : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ       <= '0;
      latchQ     <= '0;
      pullQ      <= '0;
      forceLatch <= 1'b0;
    end else begin
      if (stb.wrDir)  dirQ   <= (dirQ & ~wrMask) | (wrData & wrMask);
      if (stb.wrData) latchQ <= (latchQ & ~wrMask) | (wrData & wrMask);
      if (stb.wrPull) pullQ  <= wrData[GROUPS-1:0];
      if (stb.wrCtrl) forceLatch <= wrData[0];
    end
  end

  // pad drive: peripheral override wins over the direction bit
  assign padOe  = dirQ | periphOe;
  assign padOut = (periphOe & periphOut) | (~periphOe & latchQ);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grpLocked[g] = busMode & (|lockMask[g*GRP_SIZE +: GRP_SIZE]);
    for (genvar k = 0; k < GRP_SIZE; k++) begin : g_line
      localparam int IDX = g*GRP_SIZE + k;
      assign pullEn[IDX] = pullQ[g] & ~grpLocked[g] & ~padOe[IDX];
    end
  end

  assign dataView = forceLatch ? latchQ : ((dirQ & latchQ) | (~dirQ & pinSync));

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RD_DIR:   rdData = dirQ;
      RD_DATA:  rdData = dataView;
      RD_PULL:  rdData = {{(NUM_LINES-GROUPS){1'b0}}, pullQ};
      RD_CTRL:  rdData = {{(NUM_LINES-1){1'b0}}, forceLatch};
      RD_SENSE: rdData = {{(NUM_LINES-1){1'b0}}, senseSync};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic                 rdEn,
  output logic [NUM_LINES-1:0] rdData,
  input  logic [NUM_LINES-1:0] pinIn,
  input  logic                 senseIn,
  input  logic [NUM_LINES-1:0] periphOe,
  input  logic [NUM_LINES-1:0] periphOut,
  input  logic                 busMode,
  input  logic [NUM_LINES-1:0] lockMask,
  output logic [NUM_LINES-1:0] padOe,
  output logic [NUM_LINES-1:0] padOut,
  output logic [NUM_LINES-1:0] pullEn
);
  ctrlStrobe_t          stb;
  logic [NUM_LINES:0]   syncAll;
  logic [NUM_LINES-1:0] dirQ;
  logic [NUM_LINES-1:0] latchQ;

  gpio_port_sync #(.WIDTH(NUM_LINES + 1)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({senseIn, pinIn}),
    .syncOut(syncAll)
  );

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  gpio_port_dp #(.NUM_LINES(NUM_LINES)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .pinSync(syncAll[NUM_LINES-1:0]), .senseSync(syncAll[NUM_LINES]),
    .periphOe(periphOe), .periphOut(periphOut),
    .busMode(busMode), .lockMask(lockMask),
    .padOe(padOe), .padOut(padOut), .pullEn(pullEn),
    .rdData(rdData), .dirQ(dirQ), .latchQ(latchQ)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wrEn,
  input logic [NUM_LINES-1:0] wrData,
  input logic                 rdEn,
  input logic [NUM_LINES-1:0] rdData,
  input logic [NUM_LINES-1:0] periphOe,
  input logic [NUM_LINES-1:0] periphOut,
  input logic                 busMode,
  input logic [NUM_LINES-1:0] lockMask,
  input logic [NUM_LINES-1:0] padOe,
  input logic [NUM_LINES-1:0] padOut,
  input logic [NUM_LINES-1:0] pullEn,
  input logic [NUM_LINES-1:0] dirQ,
  input logic [NUM_LINES-1:0] latchQ
);
  a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~periphOe) == (dirQ & ~periphOe));

  a_r4_latch_takes_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(1) && !busMode) |=> latchQ == $past(wrData));

  a_r5_no_pull_when_driving: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & padOe) == '0);

  a_r6_periph_override: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & periphOe) == periphOe) &&
    ((padOut & periphOe) == (periphOut & periphOe)));

  a_r7_locked_dir_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busMode && wrEn && addr == ADDR_W'(0)) |=>
      (dirQ & $past(lockMask)) == ($past(dirQ) & $past(lockMask)));

  a_r7_locked_latch_kept: assert property (@(posedge clk) disable iff (!rstN)
    (busMode && wrEn && addr == ADDR_W'(1)) |=>
      (latchQ & $past(lockMask)) == ($past(latchQ) & $past(lockMask)));

  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);
endmodule

bind gpio_port gpio_port_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .periphOe(periphOe), .periphOut(periphOut),
  .busMode(busMode), .lockMask(lockMask), .padOe(padOe), .padOut(padOut),
  .pullEn(pullEn), .dirQ(dirQ), .latchQ(latchQ)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int NL = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [NL-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic [NL-1:0] rdData;
  logic [NL-1:0] pinIn = '0;
  logic          senseIn = 1'b0;
  logic [NL-1:0] periphOe = '0;
  logic [NL-1:0] periphOut = '0;
  logic          busMode = 1'b0;
  logic [NL-1:0] lockMask = '0;
  logic [NL-1:0] padOe, padOut, pullEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port #(.NUM_LINES(NL), .ADDR_W(AW)) i_gpio_port (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pinIn(pinIn), .senseIn(senseIn),
    .periphOe(periphOe), .periphOut(periphOut), .busMode(busMode),
    .lockMask(lockMask), .padOe(padOe), .padOut(padOut), .pullEn(pullEn)
  );

  typedef struct packed {
    logic [15:0] dirV;
    logic [15:0] dataV;
    logic [15:0] pinV;
    logic        forceV;
    logic [15:0] expRd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'hA5A5, 16'h1234, 1'b0, 16'h1234},
    '{16'hFFFF, 16'h5A5A, 16'h1234, 1'b0, 16'h5A5A},
    '{16'hFF00, 16'h1357, 16'h2468, 1'b0, 16'h1368},
    '{16'h0F0F, 16'hC3C3, 16'h9999, 1'b0, 16'h9393},
    '{16'h0000, 16'hBEEF, 16'h0000, 1'b1, 16'hBEEF},
    '{16'h00F0, 16'h1111, 16'hFFFF, 1'b1, 16'h1111}
  };

  task automatic check(input string tag, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NL-1:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", padOe, '0);
    check("R1 pullEn", pullEn, '0);
    rd(3'd0, v); check("R1 dir read", v, '0);
    rd(3'd2, v); check("R1 pull read", v, '0);
    rd(3'd3, v); check("R1 ctrl read", v, '0);

    // R2 R3 R4 R9 table walk
    for (int n = 0; n < 6; n++) begin
      wr(3'd0, VECS[n].dirV);
      wr(3'd1, VECS[n].dataV);
      wr(3'd3, {15'd0, VECS[n].forceV});
      pinIn = VECS[n].pinV;
      settle();
      rd(3'd1, v);
      check($sformatf("R3/R9 read vec%0d", n), v, VECS[n].expRd);
      check($sformatf("R2 oe vec%0d", n), padOe, VECS[n].dirV);
      check($sformatf("R4 out vec%0d", n), padOut, VECS[n].dataV);
    end
    wr(3'd3, '0);

    // R3 synchronizer latency
    wr(3'd0, '0);
    pinIn = 16'h0000; settle();
    @(negedge clk); pinIn = 16'hFFFF;
    addr = 3'd1; rdEn = 1'b1;
    @(negedge clk); check("R3 one edge still old", rdData, 16'h0000);
    @(negedge clk); check("R3 two edges new", rdData, 16'hFFFF);
    rdEn = 1'b0;

    // R4 latch written while input
    wr(3'd1, 16'h7777);
    wr(3'd3, 16'h0001);
    rd(3'd1, v); check("R4 latch while input", v, 16'h7777);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'hFFFF);
    @(negedge clk);
    check("R4 latch drives", padOut, 16'h7777);

    // R5 pull-up groups
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0005);
    @(negedge clk);
    check("R5 groups 0,2", pullEn, 16'h0F0F);
    wr(3'd0, 16'h0003);
    @(negedge clk);
    check("R5 outputs lose pull", pullEn, 16'h0F0C);
    rd(3'd2, v); check("R5 pull read", v, 16'h0005);

    // R6 peripheral override
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h000F);
    periphOe = 16'h8001; periphOut = 16'h8000;
    @(negedge clk);
    check("R6 oe", padOe, 16'h8001);
    check("R6 out", padOut, 16'h8000);
    check("R6 pull off on overridden", pullEn, 16'h7FFE);
    periphOe = '0; periphOut = '0;

    // R7 bus-mode lock
    busMode = 1'b1; lockMask = 16'h00FF;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); check("R7 dir locked bits", v, 16'hFF00);
    wr(3'd1, 16'hABCD);
    wr(3'd3, 16'h0001);
    rd(3'd1, v); check("R7 latch locked bits", v, 16'hAB01);
    wr(3'd3, 16'h0000);
    busMode = 1'b0;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); check("R7 unlocked after bus mode", v, 16'hFFFF);

    // R8 locked pull-up groups
    wr(3'd0, 16'h0000);
    busMode = 1'b1; lockMask = 16'h0010;
    wr(3'd2, 16'h000F);
    rd(3'd2, v); check("R8 pull readable", v, 16'h000F);
    check("R8 locked group off", pullEn, 16'hFF0F);
    busMode = 1'b0;
    @(negedge clk);
    check("R8 restored", pullEn, 16'hFFFF);
    lockMask = '0;

    // R10 sense line
    senseIn = 1'b1; settle();
    rd(3'd4, v); check("R10 sense high", v, 16'h0001);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); check("R10 write ignored", v, 16'h0001);
    senseIn = 1'b0; settle();
    rd(3'd4, v); check("R10 sense low", v, 16'h0000);

    // R11 idle and unused reads
    @(negedge clk);
    check("R11 idle read", rdData, '0);
    rd(3'd5, v); check("R11 unused offset", v, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule